// File: doc/BRIEF.md
# Per-Output Cell Queues for a Switch Input

This block buffers fixed-size cells at one input of a crossbar switch. It holds one logical queue for each output port, and all the queues share a single pool of cell slots. Each arriving cell carries the number of its destination output and joins the tail of that output's queue.

A separate scheduler, outside this block, issues grants. A grant names an output and takes the oldest cell from that output's queue. Cells waiting for a congested output sit in their own queue, so they never delay cells bound for outputs that are free.

The block gives the scheduler one request flag per queue. It raises a backpressure signal toward the upstream stage when the pool is close to full. When no slot is left, an arriving cell is discarded and the discard counter increases by one.

Top module: `voq_buffer`

## Requirements
- R1: After reset, every request flag is low, `out_valid` is low, `drop_cnt` is zero and all DEPTH slots are free.
- R2: When `in_valid` is high and at least one slot is free at the clock edge, the cell on `in_cell` is appended to the queue selected by `in_dest` (value k selects output k).
- R3: `req[k]` (bit k selects output k) is high exactly when queue k holds one or more cells. It changes on the edge that stores the first cell or removes the last one.
- R4: A grant (`grant_valid` high, `grant_q` = k) to a non-empty queue k removes that queue's oldest cell. In the next cycle `out_valid` is high and `out_cell` carries that cell, so each queue delivers its cells in arrival order.
- R5: A grant to an empty queue is ignored. In the next cycle `out_valid` is low, and the request flags and the contents of every queue are unchanged.
- R6: Cells held for one output do not hold back other outputs. A grant to any non-empty queue is served whatever the other queues contain.
- R7: An enqueue and a grant in the same cycle both take effect. This holds even when both name the same queue and that queue holds exactly one cell.
- R8: A cell that arrives when no slot is free at the clock edge is discarded, and `drop_cnt` increases by one. A slot freed by a grant in that same cycle does not save the cell.
- R9: `backpressure` is high exactly when the number of free slots is less than or equal to `bp_thresh`. It follows `bp_thresh` with no clock delay.
- R10: A slot emptied by a grant can be used again. Any mix of outputs can together fill all DEPTH slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An arriving cell is present |
| in_dest | input | QW | Destination output of the arriving cell |
| in_cell | input | CELL_W | Arriving cell payload |
| grant_valid | input | 1 | The scheduler grants one output this cycle |
| grant_q | input | QW | Output whose queue is served |
| out_valid | output | 1 | `out_cell` holds a dequeued cell |
| out_cell | output | CELL_W | Dequeued cell payload |
| req | output | NUM_Q | Non-empty flag for each queue |
| bp_thresh | input | FW | Free-slot level at or below which backpressure is raised |
| backpressure | output | 1 | Upstream must stop sending |
| drop_cnt | output | CNT_W | Number of discarded cells |

## Verification
The bench builds the block with four outputs, eight shared slots and 16-bit cells. With so few slots, a handful of cells fills the pool, which brings several conditions within reach: the drop case, the backpressure threshold crossing, and a refill of the whole pool after a full drain. With four queues, one queue can be kept blocked while its neighbours drain, and an enqueue can be paired with a grant on the same queue while that queue holds a single cell.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int VOQ_DEF_OUTPUTS = 4;
  localparam int VOQ_DEF_SLOTS   = 16;
  localparam int VOQ_DEF_CELL_W  = 32;
  localparam int VOQ_DEF_CNT_W   = 8;
endpackage

// File: rtl/voq_free_pool.sv
module voq_free_pool #(
  parameter int DEPTH = 16,
  localparam int SW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [SW-1:0] give_idx,
  output logic          avail,
  output logic [SW-1:0] take_idx,
  output logic [FW-1:0] free_cnt
);
  logic [DEPTH-1:0] mask_q, mask_d;
  logic [FW-1:0]    cnt_q, cnt_d;
  logic             take_fire;

  // lowest free slot wins
  always_comb begin
    take_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mask_q[i]) take_idx = SW'(i);
    end
  end

  assign avail     = |mask_q;
  assign take_fire = take && avail;
  assign free_cnt  = cnt_q;

  always_comb begin
    mask_d = mask_q;
    if (take_fire) mask_d[take_idx] = 1'b0;
    if (give)      mask_d[give_idx] = 1'b1;
    cnt_d = cnt_q + FW'(give) - FW'(take_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= {DEPTH{1'b1}};
      cnt_q  <= FW'(DEPTH);
    end else if (take_fire || give) begin
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/voq_link_ctrl.sv
module voq_link_ctrl #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16,
  localparam int QW = $clog2(NUM_Q),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_en,
  input  logic [QW-1:0]    enq_q,
  input  logic [SW-1:0]    enq_slot,
  input  logic             deq_en,
  input  logic [QW-1:0]    deq_q,
  output logic [NUM_Q-1:0] req,
  output logic [SW-1:0]    deq_slot
);
  logic [SW-1:0] head_arr [NUM_Q];
  logic [SW-1:0] tail_arr [NUM_Q];
  logic [SW-1:0] link_q   [DEPTH];
  logic          link_we;

  for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_queue
    logic [SW-1:0] hd_q, hd_d, tl_q, tl_d;
    logic          bz_q, bz_d;
    logic          enq_here, deq_here, solo;

    assign enq_here = enq_en && (enq_q == QW'(gq));
    assign deq_here = deq_en && (deq_q == QW'(gq));
    assign solo     = (hd_q == tl_q);

    always_comb begin
      hd_d = hd_q;
      tl_d = tl_q;
      bz_d = bz_q;
      if (deq_here) begin
        if (solo) bz_d = 1'b0;
        else      hd_d = link_q[hd_q];
      end
      if (enq_here) begin
        tl_d = enq_slot;
        bz_d = 1'b1;
        if (!bz_q || (deq_here && solo)) hd_d = enq_slot;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hd_q <= '0;
        tl_q <= '0;
        bz_q <= 1'b0;
      end else if (enq_here || deq_here) begin
        hd_q <= hd_d;
        tl_q <= tl_d;
        bz_q <= bz_d;
      end
    end

    assign head_arr[gq] = hd_q;
    assign tail_arr[gq] = tl_q;
    assign req[gq]      = bz_q;
  end

  assign link_we  = enq_en && req[enq_q];
  assign deq_slot = head_arr[deq_q];

  always_ff @(posedge clk) begin
    if (link_we) link_q[tail_arr[enq_q]] <= enq_slot;
  end
endmodule

// File: rtl/voq_cell_store.sv
module voq_cell_store #(
  parameter int DEPTH  = 16,
  parameter int CELL_W = 32,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_idx,
  input  logic [CELL_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SW-1:0]     rd_idx,
  output logic              rd_valid,
  output logic [CELL_W-1:0] rd_data
);
  logic [CELL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer #(
  parameter int NUM_Q  = voq_pkg::VOQ_DEF_OUTPUTS,
  parameter int DEPTH  = voq_pkg::VOQ_DEF_SLOTS,
  parameter int CELL_W = voq_pkg::VOQ_DEF_CELL_W,
  parameter int CNT_W  = voq_pkg::VOQ_DEF_CNT_W,
  localparam int QW = $clog2(NUM_Q),
  localparam int SW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [QW-1:0]     in_dest,
  input  logic [CELL_W-1:0] in_cell,
  input  logic              grant_valid,
  input  logic [QW-1:0]     grant_q,
  output logic              out_valid,
  output logic [CELL_W-1:0] out_cell,
  output logic [NUM_Q-1:0]  req,
  input  logic [FW-1:0]     bp_thresh,
  output logic              backpressure,
  output logic [CNT_W-1:0]  drop_cnt
);
  logic          avail, enq_fire, deq_fire, drop_now;
  logic [SW-1:0] new_slot, head_slot;
  logic [FW-1:0] free_cnt;
  logic [CNT_W-1:0] drop_q, drop_d;

  assign enq_fire = in_valid && avail;
  assign drop_now = in_valid && !avail;
  assign deq_fire = grant_valid && req[grant_q];

  voq_free_pool #(.DEPTH(DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .take(in_valid), .give(deq_fire), .give_idx(head_slot),
    .avail(avail), .take_idx(new_slot), .free_cnt(free_cnt)
  );

  voq_link_ctrl #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_links (
    .clk(clk), .rst_n(rst_n),
    .enq_en(enq_fire), .enq_q(in_dest), .enq_slot(new_slot),
    .deq_en(deq_fire), .deq_q(grant_q),
    .req(req), .deq_slot(head_slot)
  );

  voq_cell_store #(.DEPTH(DEPTH), .CELL_W(CELL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(enq_fire), .wr_idx(new_slot), .wr_data(in_cell),
    .rd_en(deq_fire), .rd_idx(head_slot),
    .rd_valid(out_valid), .rd_data(out_cell)
  );

  assign drop_d = drop_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drop_q <= '0;
    else if (drop_now) drop_q <= drop_d;
  end

  assign drop_cnt     = drop_q;
  assign backpressure = (free_cnt <= bp_thresh);
endmodule

// File: rtl/voq_buffer_chk.sv
module voq_buffer_chk #(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  localparam int QW = $clog2(NUM_Q),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             grant_valid,
  input logic [QW-1:0]    grant_q,
  input logic             out_valid,
  input logic [NUM_Q-1:0] req,
  input logic [CNT_W-1:0] drop_cnt,
  input logic [FW-1:0]    free_cnt
);
  // R4: a served grant yields a cell one cycle later
  a_r4_out_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req[grant_q]) |=> out_valid);

  // R5: nothing leaves without a grant on a non-empty queue
  a_r5_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && req[grant_q]) |=> !out_valid);

  // R8: an arrival at a full pool bumps the discard count
  a_r8_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && free_cnt == '0) |=> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

  // R8: the discard count moves for nothing else
  a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && free_cnt == '0) |=> $stable(drop_cnt));

  // R3: all queues empty means every slot is back in the pool
  a_r3_empty_all_free: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (free_cnt == FW'(DEPTH)));

  // R3: flags hold when nothing enters or leaves
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !grant_valid) |=> $stable(req));

  // R10: the pool never reports more slots than exist
  a_r10_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FW'(DEPTH));
endmodule

bind voq_buffer voq_buffer_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grant_valid(grant_valid),
  .grant_q(grant_q), .out_valid(out_valid), .req(req), .drop_cnt(drop_cnt),
  .free_cnt(free_cnt)
);

// File: tb/tb_voq_buffer.sv
`timescale 1ns/1ps
module tb_voq_buffer;
  localparam int NQ = 4;
  localparam int DP = 8;
  localparam int CW = 16;
  localparam int KW = 8;

  logic          clk, rst_n;
  logic          in_valid, grant_valid;
  logic [1:0]    in_dest, grant_q;
  logic [CW-1:0] in_cell, out_cell;
  logic          out_valid, backpressure;
  logic [NQ-1:0] req;
  logic [3:0]    bp_thresh;
  logic [KW-1:0] drop_cnt;

  voq_buffer #(.NUM_Q(NQ), .DEPTH(DP), .CELL_W(CW), .CNT_W(KW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_cell(in_cell), .grant_valid(grant_valid), .grant_q(grant_q),
    .out_valid(out_valid), .out_cell(out_cell), .req(req),
    .bp_thresh(bp_thresh), .backpressure(backpressure), .drop_cnt(drop_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk, nfail;
  bit done;
  // reference queues
  logic [CW-1:0] mdat [NQ][64];
  int mrd [NQ];
  int mwr [NQ];
  int mfree, mdrop;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NQ-1:0] exp_req();
    logic [NQ-1:0] r;
    for (int k = 0; k < NQ; k++) r[k] = (mwr[k] != mrd[k]);
    return r;
  endfunction

  task automatic cyc(string tag, bit iv, int idst, logic [CW-1:0] icell, bit gv, int gq);
    bit            can_enq, eov;
    logic [CW-1:0] ecell;
    can_enq = (mfree > 0);
    in_valid = iv; in_dest = 2'(idst); in_cell = icell;
    grant_valid = gv; grant_q = 2'(gq);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; grant_valid = 1'b0;
    eov = 1'b0; ecell = '0;
    if (gv && mwr[gq] != mrd[gq]) begin
      ecell = mdat[gq][mrd[gq]]; mrd[gq]++; eov = 1'b1; mfree++;
    end
    if (iv) begin
      if (can_enq) begin mdat[idst][mwr[idst]] = icell; mwr[idst]++; mfree--; end
      else mdrop++;
    end
    chk({tag, " out_valid"}, 32'(out_valid), 32'(eov));
    if (eov) chk({tag, " out_cell"}, 32'(out_cell), 32'(ecell));
    chk({tag, " req"}, 32'(req), 32'(exp_req()));
    chk({tag, " drop_cnt"}, 32'(drop_cnt), 32'(mdrop));
    chk({tag, " backpressure"}, 32'(backpressure), 32'(mfree <= int'(bp_thresh)));
  endtask

  task automatic t_reset();
    chk("R1 req", 32'(req), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 drop_cnt", 32'(drop_cnt), 0);
    bp_thresh = 4'd7; #1;
    chk("R1 all free, backpressure low at 7", 32'(backpressure), 0);
    bp_thresh = 4'd8; #1;
    chk("R9 backpressure high at threshold 8", 32'(backpressure), 1);
    bp_thresh = 4'd2; #1;
  endtask

  task automatic t_order();
    cyc("R2 enq q2", 1, 2, 16'hA1, 0, 0);
    cyc("R2 enq q2", 1, 2, 16'hA2, 0, 0);
    cyc("R3 enq q2", 1, 2, 16'hA3, 0, 0);
    chk("R3 only q2 flag", 32'(req), 32'h4);
    for (int i = 0; i < 3; i++) cyc("R4 fifo q2", 0, 0, 0, 1, 2);
    chk("R3 q2 empty", 32'(req), 0);
  endtask

  task automatic t_empty_grant();
    cyc("R5 grant empty q1", 0, 0, 0, 1, 1);
    cyc("R5 enq q0", 1, 0, 16'hB7, 0, 0);
    cyc("R5 grant empty q3", 0, 0, 0, 1, 3);
    chk("R5 q0 untouched", 32'(req), 32'h1);
    cyc("R5 q0 intact", 0, 0, 0, 1, 0);
  endtask

  task automatic t_hol();
    cyc("R6 enq q0", 1, 0, 16'hC0, 0, 0);
    cyc("R6 enq q0", 1, 0, 16'hC1, 0, 0);
    cyc("R6 enq q1", 1, 1, 16'hD0, 0, 0);
    cyc("R6 serve q1 past q0", 0, 0, 0, 1, 1);
    chk("R6 q0 still waiting", 32'(req), 32'h1);
    cyc("R6 drain q0", 0, 0, 0, 1, 0);
    cyc("R6 drain q0", 0, 0, 0, 1, 0);
  endtask

  task automatic t_same_cycle();
    cyc("R7 enq q3", 1, 3, 16'hE0, 0, 0);
    cyc("R7 enq q2 grant q3", 1, 2, 16'hF0, 1, 3);
    cyc("R7 enq+grant single q2", 1, 2, 16'hF1, 1, 2);
    chk("R7 q2 holds one", 32'(req), 32'h4);
    cyc("R7 drain q2", 0, 0, 0, 1, 2);
  endtask

  task automatic t_full();
    for (int i = 0; i < DP; i++) begin
      cyc("R9 fill", 1, i % NQ, CW'(16'h100 + i), 0, 0);
      if (i == 4) chk("R9 free 3 above thresh", 32'(backpressure), 0);
      if (i == 5) chk("R9 free 2 at thresh", 32'(backpressure), 1);
    end
    cyc("R8 drop when full", 1, 1, 16'hDEAD, 0, 0);
    chk("R8 one drop", 32'(drop_cnt), 1);
    cyc("R8 grant does not rescue", 1, 0, 16'hBEEF, 1, 0);
    chk("R8 two drops", 32'(drop_cnt), 2);
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < NQ; k++) cyc("R10 drain mixed", 0, 0, 0, 1, k);
    chk("R10 all empty", 32'(req), 0);
    for (int i = 0; i < DP; i++) cyc("R10 refill q3", 1, 3, CW'(16'h200 + i), 0, 0);
    chk("R10 no new drops", 32'(drop_cnt), 2);
    for (int i = 0; i < DP; i++) cyc("R10 drain q3", 0, 0, 0, 1, 3);
  endtask

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    mfree = DP; mdrop = 0;
    for (int k = 0; k < NQ; k++) begin mrd[k] = 0; mwr[k] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; grant_valid = 1'b0;
    in_dest = '0; grant_q = '0; in_cell = '0; bp_thresh = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty_grant();
    t_hol();
    t_same_cycle();
    t_full();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule